// File: doc/BRIEF.md
# Codec Power-Up Sequencer

This block runs on the host side of an audio converter and takes it from the moment its supplies come up to normal streaming operation. It keeps the converter's reset line low until a supply-good input has stayed high for a programmable number of clock cycles. It then releases reset and sends a fixed series of control-register writes through a request/acknowledge command port to an external bus master. The first write sets the power-down bit. Next comes a short configuration list, then the master clock is enabled, and a final write clears the power-down bit.

Once that last write is acknowledged, the sequencer starts the serial bit clock and frame clock and enables the serial data path. It counts a fixed number of frame-clock rising edges, one per sample period, and then raises `ready`. If the bus master answers any write with a not-acknowledge, the sequencer parks in a fault state with `error` high. A supply drop at any point puts the converter back in reset, clears every output and restarts the whole sequence.

Top module: `codec_pwrup_seq`

## Requirements
- R1: While `rst_n` is low, and in the first cycle after it rises, `codec_rst_n`, `cmd_req`, `mclk_en`, `bit_clk`, `frame_clk`, `sdata_en`, `ready` and `error` are all 0.
- R2: `codec_rst_n` rises at the (`dbnc_len`+2)-th rising clock edge that samples `supply_good` high without interruption. Any cycle in which it is sampled low restarts this count.
- R3: No write is requested while `codec_rst_n` is low. The first write after release targets address 0x02 with data 0x01, which sets the power-down bit (bit 0).
- R4: After that first write, exactly five configuration writes follow in this order: (0x03,0x4A), (0x04,0x36), (0x05,0x1C), (0x06,0x00), (0x08,0x7F). An internal terminator entry ends the list.
- R5: `cmd_req` stays high, with `cmd_addr` and `cmd_data` unchanged, until a cycle in which `cmd_ack` or `cmd_nack` is sampled high. It is low in the next cycle. Consecutive requests are separated by at least one idle cycle.
- R6: `mclk_en` is 0 during the power-down-set write and all configuration writes. It is 1 before the clearing write (0x02, 0x00) is requested, and that is the last write of the sequence.
- R7: `bit_clk`, `frame_clk` and `sdata_en` stay 0 until the clearing write is acknowledged, then start. `bit_clk` has a period of 2·BCLK_HALF cycles. `frame_clk` has a period of FRAME_BITS bit-clock periods and changes only together with a falling `bit_clk`.
- R8: `ready` rises in the cycle after the SETTLE_FRAMES-th rising edge of `frame_clk`. It then stays high, with the clocks running, as long as `supply_good` is high.
- R9: A `cmd_nack` on any write sets `error` in the next cycle. `cmd_req`, `mclk_en`, `sdata_en`, `ready` and `codec_rst_n` go low and stay low while `supply_good` stays high.
- R10: One cycle after `supply_good` is sampled low, `codec_rst_n`, `cmd_req`, `mclk_en`, `sdata_en`, `ready` and `error` are all 0, and the sequence restarts as in R2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sequencer clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| supply_good | input | 1 | High while the converter supply is within range |
| dbnc_len | input | DBNC_W | Supply debounce length in cycles |
| codec_rst_n | output | 1 | Active-low reset to the converter |
| cmd_req | output | 1 | Register write request to the bus master |
| cmd_addr | output | 8 | Register address of the pending write |
| cmd_data | output | 8 | Data byte of the pending write |
| cmd_ack | input | 1 | Write completed and acknowledged |
| cmd_nack | input | 1 | Write not acknowledged |
| mclk_en | output | 1 | Master clock enable |
| bit_clk | output | 1 | Serial bit clock |
| frame_clk | output | 1 | Frame (sample-rate) clock |
| sdata_en | output | 1 | Serial data path enable |
| ready | output | 1 | Converter settled and ready |
| error | output | 1 | A write was not acknowledged |

## Verification
The bench sweeps debounce lengths against acknowledge latencies. It checks the exact cycle of reset release, so an off-by-one in the debounce counter shows up as an early or late rise, and a debouncer that ignores a one-cycle glitch releases reset too soon. It injects a not-acknowledge at every write position and a supply drop at every write position. A sequencer that skipped the fault path, or did not restart from the power-down-set write, would show a wrong first write or a stray `ready`. Clock periods and the ready cycle are computed from the parameters, which catches a settle count that is off by one frame or clocks that start before the clearing write.

// File: rtl/pwrseq_pkg.sv
package pwrseq_pkg;

    typedef enum logic [2:0] {
        SEQ_HOLD    = 3'd0,
        SEQ_PDN_SET = 3'd1,
        SEQ_CFG     = 3'd2,
        SEQ_MCLK    = 3'd3,
        SEQ_PDN_CLR = 3'd4,
        SEQ_SETTLE  = 3'd5,
        SEQ_READY   = 3'd6,
        SEQ_FAULT   = 3'd7
    } seq_state_e;

    localparam logic [7:0] PWR_REG_ADDR = 8'h02;
    localparam logic [7:0] PWR_DOWN_SET = 8'h01;
    localparam logic [7:0] PWR_DOWN_CLR = 8'h00;

    typedef struct packed {
        logic       last;
        logic [7:0] addr;
        logic [7:0] data;
    } cfg_entry_t;

endpackage

// File: rtl/pwrseq_debounce.sv
module pwrseq_debounce #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             supply_good,
    input  logic [CNT_W-1:0] len,
    output logic             stable
);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             ok;
    } dbn_t;

    dbn_t dbn_d, dbn_q;

    always_comb begin
        dbn_d = dbn_q;
        if (!supply_good) begin
            dbn_d.cnt = '0;
            dbn_d.ok  = 1'b0;
        end else if (dbn_q.cnt >= len) begin
            dbn_d.ok = 1'b1;
        end else begin
            dbn_d.cnt = dbn_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) dbn_q <= '0;
        else        dbn_q <= dbn_d;
    end

    assign stable = dbn_q.ok;

endmodule

// File: rtl/pwrseq_cfg_rom.sv
module pwrseq_cfg_rom #(
    parameter int IDX_W = 3
) (
    input  logic [IDX_W-1:0]        idx,
    output pwrseq_pkg::cfg_entry_t  entry
);

    // R4: configuration list, terminated by an entry with last set
    always_comb begin
        entry = '{last: 1'b1, addr: 8'h00, data: 8'h00};
        case (int'(idx))
            0: entry = '{last: 1'b0, addr: 8'h03, data: 8'h4A};
            1: entry = '{last: 1'b0, addr: 8'h04, data: 8'h36};
            2: entry = '{last: 1'b0, addr: 8'h05, data: 8'h1C};
            3: entry = '{last: 1'b0, addr: 8'h06, data: 8'h00};
            4: entry = '{last: 1'b0, addr: 8'h08, data: 8'h7F};
            default: entry = '{last: 1'b1, addr: 8'h00, data: 8'h00};
        endcase
    end

endmodule

// File: rtl/pwrseq_clkgen.sv
module pwrseq_clkgen #(
    parameter int BCLK_HALF  = 2,
    parameter int FRAME_BITS = 64
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    output logic bit_clk,
    output logic frame_clk,
    output logic frame_rise
);

    localparam int HALF_BITS = FRAME_BITS / 2;
    localparam int DIV_W     = $clog2(BCLK_HALF + 1);
    localparam int BIT_W     = $clog2(HALF_BITS + 1);

    typedef struct packed {
        logic [DIV_W-1:0] div;
        logic [BIT_W-1:0] bits;
        logic             bclk;
        logic             fclk;
        logic             rise;
    } gen_t;

    gen_t gen_d, gen_q;

    always_comb begin
        gen_d      = gen_q;
        gen_d.rise = 1'b0;
        if (!en) begin
            gen_d = '0;
        end else if (gen_q.div == DIV_W'(BCLK_HALF - 1)) begin
            gen_d.div  = '0;
            gen_d.bclk = !gen_q.bclk;
            if (gen_q.bclk) begin
                // frame clock moves only on a falling bit clock
                if (gen_q.bits == BIT_W'(HALF_BITS - 1)) begin
                    gen_d.bits = '0;
                    gen_d.fclk = !gen_q.fclk;
                    gen_d.rise = !gen_q.fclk;
                end else begin
                    gen_d.bits = gen_q.bits + 1'b1;
                end
            end
        end else begin
            gen_d.div = gen_q.div + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) gen_q <= '0;
        else        gen_q <= gen_d;
    end

    assign bit_clk    = gen_q.bclk;
    assign frame_clk  = gen_q.fclk;
    assign frame_rise = gen_q.rise;

endmodule

// File: rtl/codec_pwrup_seq.sv
module codec_pwrup_seq
    import pwrseq_pkg::*;
#(
    parameter int DBNC_W        = 16,
    parameter int BCLK_HALF     = 2,
    parameter int FRAME_BITS    = 64,
    parameter int SETTLE_FRAMES = 2000,
    parameter int CFG_IDX_W     = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              supply_good,
    input  logic [DBNC_W-1:0] dbnc_len,
    output logic              codec_rst_n,
    output logic              cmd_req,
    output logic [7:0]        cmd_addr,
    output logic [7:0]        cmd_data,
    input  logic              cmd_ack,
    input  logic              cmd_nack,
    output logic              mclk_en,
    output logic              bit_clk,
    output logic              frame_clk,
    output logic              sdata_en,
    output logic              ready,
    output logic              error
);

    localparam int SET_W = $clog2(SETTLE_FRAMES + 1);

    typedef struct packed {
        seq_state_e           st;
        logic                 rst_out;
        logic                 req;
        logic [7:0]           addr;
        logic [7:0]           data;
        logic [CFG_IDX_W-1:0] idx;
        logic [SET_W-1:0]     cnt;
        logic                 mclk;
        logic                 run;
        logic                 rdy;
        logic                 err;
    } seq_t;

    seq_t       seq_d, seq_q;
    logic       supply_stable;
    logic       frame_rise;
    cfg_entry_t cfg_entry;

    pwrseq_debounce #(.CNT_W(DBNC_W)) u_dbnc (
        .clk         (clk),
        .rst_n       (rst_n),
        .supply_good (supply_good),
        .len         (dbnc_len),
        .stable      (supply_stable)
    );

    pwrseq_cfg_rom #(.IDX_W(CFG_IDX_W)) u_rom (
        .idx   (seq_q.idx),
        .entry (cfg_entry)
    );

    // enable follows the next-state value so clocks stop with sdata_en
    pwrseq_clkgen #(.BCLK_HALF(BCLK_HALF), .FRAME_BITS(FRAME_BITS)) u_clk (
        .clk        (clk),
        .rst_n      (rst_n),
        .en         (seq_d.run),
        .bit_clk    (bit_clk),
        .frame_clk  (frame_clk),
        .frame_rise (frame_rise)
    );

    always_comb begin
        seq_d = seq_q;
        case (seq_q.st)
            SEQ_HOLD: begin
                seq_d.rst_out = 1'b0;
                if (supply_stable) begin
                    seq_d.st      = SEQ_PDN_SET;
                    seq_d.rst_out = 1'b1;
                end
            end
            SEQ_PDN_SET: begin
                if (!seq_q.req) begin
                    seq_d.req  = 1'b1;
                    seq_d.addr = PWR_REG_ADDR;
                    seq_d.data = PWR_DOWN_SET;
                end else if (cmd_ack) begin
                    seq_d.req = 1'b0;
                    seq_d.idx = '0;
                    seq_d.st  = SEQ_CFG;
                end
            end
            SEQ_CFG: begin
                if (!seq_q.req) begin
                    if (cfg_entry.last) begin
                        seq_d.st = SEQ_MCLK;
                    end else begin
                        seq_d.req  = 1'b1;
                        seq_d.addr = cfg_entry.addr;
                        seq_d.data = cfg_entry.data;
                    end
                end else if (cmd_ack) begin
                    seq_d.req = 1'b0;
                    seq_d.idx = seq_q.idx + 1'b1;
                end
            end
            SEQ_MCLK: begin
                seq_d.mclk = 1'b1;
                seq_d.st   = SEQ_PDN_CLR;
            end
            SEQ_PDN_CLR: begin
                if (!seq_q.req) begin
                    seq_d.req  = 1'b1;
                    seq_d.addr = PWR_REG_ADDR;
                    seq_d.data = PWR_DOWN_CLR;
                end else if (cmd_ack) begin
                    seq_d.req = 1'b0;
                    seq_d.run = 1'b1;
                    seq_d.cnt = '0;
                    seq_d.st  = SEQ_SETTLE;
                end
            end
            SEQ_SETTLE: begin
                if (frame_rise) begin
                    if (seq_q.cnt == SET_W'(SETTLE_FRAMES - 1)) begin
                        seq_d.rdy = 1'b1;
                        seq_d.st  = SEQ_READY;
                    end else begin
                        seq_d.cnt = seq_q.cnt + 1'b1;
                    end
                end
            end
            SEQ_READY: begin
                seq_d.rdy = 1'b1;
            end
            SEQ_FAULT: begin
                seq_d.err = 1'b1;
            end
            default: begin
                seq_d = '0;
            end
        endcase

        // a refused write parks the sequencer
        if (seq_q.req && cmd_nack) begin
            seq_d         = '0;
            seq_d.st      = SEQ_FAULT;
            seq_d.err     = 1'b1;
        end

        // supply loss overrides everything and restarts
        if (!supply_good) begin
            seq_d = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) seq_q <= '0;
        else        seq_q <= seq_d;
    end

    assign codec_rst_n = seq_q.rst_out;
    assign cmd_req     = seq_q.req;
    assign cmd_addr    = seq_q.addr;
    assign cmd_data    = seq_q.data;
    assign mclk_en     = seq_q.mclk;
    assign sdata_en    = seq_q.run;
    assign ready       = seq_q.rdy;
    assign error       = seq_q.err;

endmodule

// File: rtl/pwrseq_checker.sv
module pwrseq_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       supply_good,
    input logic       codec_rst_n,
    input logic       cmd_req,
    input logic [7:0] cmd_addr,
    input logic [7:0] cmd_data,
    input logic       cmd_ack,
    input logic       cmd_nack,
    input logic       mclk_en,
    input logic       bit_clk,
    input logic       frame_clk,
    input logic       sdata_en,
    input logic       ready,
    input logic       error
);

    AST_NO_WRITE_IN_RESET: assert property (@(posedge clk) disable iff (!rst_n)
        !codec_rst_n |-> !cmd_req);                                              // R3

    AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_req && !cmd_ack && !cmd_nack && supply_good
        |=> cmd_req && $stable(cmd_addr) && $stable(cmd_data));                  // R5

    AST_REQ_DROP: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_req && (cmd_ack || cmd_nack) |=> !cmd_req);                          // R5

    AST_MCLK_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
        (bit_clk || frame_clk || sdata_en) |-> mclk_en);                         // R6

    AST_FRAME_ON_BCLK_FALL: assert property (@(posedge clk) disable iff (!rst_n)
        sdata_en && $past(sdata_en) && !$stable(frame_clk) |-> $fell(bit_clk));  // R7

    AST_READY_RUNNING: assert property (@(posedge clk) disable iff (!rst_n)
        ready |-> sdata_en && mclk_en && codec_rst_n && !error);                 // R8

    AST_FAULT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        error |-> !cmd_req && !ready && !mclk_en && !sdata_en && !codec_rst_n);  // R9

    AST_DROP_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        !supply_good |=> !codec_rst_n && !cmd_req && !ready && !mclk_en && !error); // R10

endmodule

bind codec_pwrup_seq pwrseq_checker u_pwrseq_checker (
    .clk         (clk),
    .rst_n       (rst_n),
    .supply_good (supply_good),
    .codec_rst_n (codec_rst_n),
    .cmd_req     (cmd_req),
    .cmd_addr    (cmd_addr),
    .cmd_data    (cmd_data),
    .cmd_ack     (cmd_ack),
    .cmd_nack    (cmd_nack),
    .mclk_en     (mclk_en),
    .bit_clk     (bit_clk),
    .frame_clk   (frame_clk),
    .sdata_en    (sdata_en),
    .ready       (ready),
    .error       (error)
);

// File: tb/codec_pwrup_seq_test.sv
`timescale 1ns/1ps
module codec_pwrup_seq_test;

    localparam int DBNC_W        = 8;
    localparam int BCLK_HALF     = 2;
    localparam int FRAME_BITS    = 8;
    localparam int SETTLE_FRAMES = 6;
    localparam int BIT_PER       = 2 * BCLK_HALF;
    localparam int FRAME_PER     = FRAME_BITS * BIT_PER;
    localparam int NWR           = 7;

    logic              clk = 1'b0;
    logic              rst_n;
    logic              supply_good;
    logic [DBNC_W-1:0] dbnc_len;
    logic              codec_rst_n, cmd_req, cmd_ack, cmd_nack;
    logic [7:0]        cmd_addr, cmd_data;
    logic              mclk_en, bit_clk, frame_clk, sdata_en, ready, error;

    int total = 0;
    int bad   = 0;

    // expected write list: power-down set, five config writes, power-down clear
    logic [7:0] exp_a [NWR] = '{8'h02, 8'h03, 8'h04, 8'h05, 8'h06, 8'h08, 8'h02};
    logic [7:0] exp_d [NWR] = '{8'h01, 8'h4A, 8'h36, 8'h1C, 8'h00, 8'h7F, 8'h00};

    always #10 clk = ~clk;

    codec_pwrup_seq #(
        .DBNC_W(DBNC_W), .BCLK_HALF(BCLK_HALF), .FRAME_BITS(FRAME_BITS),
        .SETTLE_FRAMES(SETTLE_FRAMES), .CFG_IDX_W(3)
    ) uut (
        .clk(clk), .rst_n(rst_n), .supply_good(supply_good), .dbnc_len(dbnc_len),
        .codec_rst_n(codec_rst_n), .cmd_req(cmd_req), .cmd_addr(cmd_addr),
        .cmd_data(cmd_data), .cmd_ack(cmd_ack), .cmd_nack(cmd_nack),
        .mclk_en(mclk_en), .bit_clk(bit_clk), .frame_clk(frame_clk),
        .sdata_en(sdata_en), .ready(ready), .error(error)
    );

    task automatic chk(input bit ok, input string req, input longint act,
                       input longint exp, input string what);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    function automatic logic [7:0] outs();
        return {codec_rst_n, cmd_req, mclk_en, bit_clk, frame_clk, sdata_en, ready, error};
    endfunction

    // one full sequence; nack_at / drop_at select a write index (>= NWR means none)
    task automatic run_seq(input int dbnc, input int lat, input int nack_at, input int drop_at);
        int cyc, wr, rsp, wait_n, rises_b, rises_f, last_b, last_f, nth_cyc;
        bit prev_b, prev_f, seen_rst, done, nacked;
        logic [7:0] hold_a, hold_d;
        supply_good = 1'b0; cmd_ack = 1'b0; cmd_nack = 1'b0;
        dbnc_len = DBNC_W'(dbnc);
        repeat (3) @(negedge clk);
        chk(outs() == 8'h00, "R10", outs(), 0, "idle while supply low");
        supply_good = 1'b1;
        cyc = 0; wr = 0; rsp = 0; wait_n = 0; rises_b = 0; rises_f = 0;
        last_b = 0; last_f = 0; nth_cyc = -10; prev_b = 0; prev_f = 0;
        seen_rst = 0; done = 0; nacked = 0; hold_a = 0; hold_d = 0;
        while (!done && cyc < 4000) begin
            @(negedge clk);
            cyc++;
            if (!seen_rst && codec_rst_n) begin
                seen_rst = 1;
                chk(cyc == dbnc + 2, "R2", cyc, dbnc + 2, "reset release cycle");
            end
            if (!codec_rst_n && cmd_req) chk(0, "R3", 1, 0, "request during reset");
            if (!sdata_en && (bit_clk || frame_clk))
                chk(0, "R7", {bit_clk, frame_clk}, 0, "clock without enable");
            if (sdata_en && bit_clk && !prev_b) begin
                if (rises_b > 0) chk(cyc - last_b == BIT_PER, "R7", cyc - last_b, BIT_PER, "bit clock period");
                last_b = cyc; rises_b++;
            end
            if (sdata_en && frame_clk && !prev_f) begin
                if (rises_f > 0) chk(cyc - last_f == FRAME_PER, "R7", cyc - last_f, FRAME_PER, "frame period");
                last_f = cyc; rises_f++;
                if (rises_f == SETTLE_FRAMES) begin
                    nth_cyc = cyc;
                    chk(!ready, "R8", ready, 0, "ready before count ends");
                end
            end
            prev_b = bit_clk; prev_f = frame_clk;
            if (ready) begin
                chk(cyc == nth_cyc + 1, "R8", cyc, nth_cyc + 1, "ready cycle");
                done = 1;
            end
            case (rsp)
                0: if (cmd_req) begin
                    if (wr < NWR) begin
                        chk(cmd_addr == exp_a[wr] && cmd_data == exp_d[wr], wr == 0 ? "R3" : "R4",
                            {cmd_addr, cmd_data}, {exp_a[wr], exp_d[wr]}, "write contents");
                        chk(mclk_en == (wr == NWR - 1), "R6", mclk_en, wr == NWR - 1, "mclk at write");
                        chk(!sdata_en && !bit_clk, "R7", {sdata_en, bit_clk}, 0, "clocks during writes");
                    end else chk(0, "R4", wr, NWR - 1, "extra write");
                    hold_a = cmd_addr; hold_d = cmd_data;
                    if (wr == drop_at) begin
                        supply_good = 1'b0; rsp = 3;
                    end else if (lat == 0) begin
                        if (wr == nack_at) begin cmd_nack = 1'b1; nacked = 1; end
                        else cmd_ack = 1'b1;
                        rsp = 2;
                    end else begin
                        wait_n = lat; rsp = 1;
                    end
                end
                1: begin
                    chk(cmd_req && cmd_addr == hold_a && cmd_data == hold_d, "R5",
                        {cmd_req, cmd_addr, cmd_data}, {1'b1, hold_a, hold_d}, "request held");
                    wait_n--;
                    if (wait_n == 0) begin
                        if (wr == nack_at) begin cmd_nack = 1'b1; nacked = 1; end
                        else cmd_ack = 1'b1;
                        rsp = 2;
                    end
                end
                2: begin
                    cmd_ack = 1'b0; cmd_nack = 1'b0;
                    chk(!cmd_req, "R5", cmd_req, 0, "request dropped after response");
                    if (nacked) begin
                        chk(error && !codec_rst_n && !mclk_en, "R9", {error, codec_rst_n, mclk_en}, 3'b100, "fault entry");
                        done = 1;
                    end
                    wr++; rsp = 0;
                end
                default: begin
                    chk(!codec_rst_n && !cmd_req && !mclk_en, "R10",
                        {codec_rst_n, cmd_req, mclk_en}, 0, "drop during writes");
                    done = 1;
                end
            endcase
        end
        if (!done) chk(0, "R8", cyc, 0, "sequence timeout");
        if (nack_at < NWR) begin
            repeat (5) begin
                @(negedge clk);
                chk(outs() == 8'h01, "R9", outs(), 8'h01, "fault held");
            end
        end else if (drop_at >= NWR) begin
            chk(wr == NWR, "R6", wr, NWR, "write count");
            repeat (40) begin
                @(negedge clk);
                chk(ready && sdata_en && mclk_en && codec_rst_n, "R8",
                    {ready, sdata_en, mclk_en, codec_rst_n}, 4'hF, "ready held");
            end
        end
        supply_good = 1'b0;
        @(negedge clk);
        chk(outs() == 8'h00, "R10", outs(), 0, "supply drop clears outputs");
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog: actual=expired expected=finished");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        int cyc;
        rst_n = 1'b0; supply_good = 1'b0; cmd_ack = 1'b0; cmd_nack = 1'b0; dbnc_len = '0;
        repeat (3) @(negedge clk);
        chk(outs() == 8'h00, "R1", outs(), 0, "outputs in reset");
        rst_n = 1'b1;
        @(negedge clk);
        chk(outs() == 8'h00, "R1", outs(), 0, "outputs after reset");

        for (int d = 0; d < 4; d++)
            for (int l = 0; l < 4; l++)
                run_seq(d, l, NWR, NWR);

        for (int k = 0; k < NWR; k++) run_seq(1, k % 3, k, NWR);   // R9 at each write
        for (int k = 0; k < NWR; k++) run_seq(0, 1, NWR, k);       // R10 at each write

        // R2: glitch restarts the debounce count
        supply_good = 1'b0; dbnc_len = 8'd4;
        repeat (3) @(negedge clk);
        supply_good = 1'b1;
        repeat (3) begin
            @(negedge clk);
            chk(!codec_rst_n, "R2", codec_rst_n, 0, "reset held before expiry");
        end
        supply_good = 1'b0;
        @(negedge clk);
        chk(!codec_rst_n, "R2", codec_rst_n, 0, "reset held on glitch");
        supply_good = 1'b1;
        cyc = 0;
        while (!codec_rst_n && cyc < 20) begin
            @(negedge clk);
            cyc++;
        end
        chk(cyc == 6, "R2", cyc, 6, "release after glitch restart");
        supply_good = 1'b0;
        @(negedge clk);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule